// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block buffers 24-bit audio samples between a register-mapped processor port and an audio serializer. One instance serves one direction, chosen by a parameter. For playback, the processor writes samples into a data register and the serializer takes one sample per channel slot. For capture, the serializer deposits one sample per slot and the processor reads them from the data register. Samples are interleaved: a frame is one word per channel, in channel order.

The memory holds 256 words scaled up by a 3-bit size code. The size code is clamped to the largest capacity the instance was built with. The channel count is rounded up to a power-of-two group, and the per-channel depth shrinks by one halving for every doubling of that group. The block holds at most depth times channels words. Status reports the fill level in frames, sticky overrun and underrun flags, and an optional interrupt tied to the half-full mark.

The processor uses three registers: control, status and data. The clear, interrupt-enable and flag bits sit at fixed positions so that existing software can drive the block.

Top module: `pcm_sample_fifo`

## Requirements
- R1: After reset, the control register (select 0) and the status register (select 1) both read zero, and `irq` is low.
- R2: In playback, each processor write to the data register (select 2) queues `reg_wdata[23:0]`, and the upper bits are dropped. Each `ser_strobe` presents the oldest queued word on `ser_rdata` during that cycle and removes it, so words come out in the order they were written.
- R3: Capacity is 256 << min(`cfg_size`, MAX_SIZE_CODE) words. The per-channel depth is that capacity halved once per doubling needed to reach `cfg_chan_m1`+1 channels (3 channels count as 4; 5 to 7 count as 8). The FIFO accepts depth × channels words.
- R4: Status bits [16:8] give the fill level in frames: the frames whose last word was pushed, minus the frames whose last word was popped. The field saturates at 511.
- R5: A push into a full FIFO is dropped, sets the overrun flag (status bit 4), and leaves the stored words unchanged.
- R6: A pop from an empty FIFO returns zero and sets the underrun flag (status bit 0).
- R7: A status write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1, so writing zero clears both.
- R8: Writing control bit 0 empties the FIFO in one cycle, with level zero and the next pop underrunning. The flags are left unchanged, and bit 0 reads back as 0.
- R9: Control bit 20 enables the interrupt. In playback, `irq` is high while the interrupt is enabled and the level is at or below half the per-channel depth.
- R10: In capture, each `ser_strobe` queues `ser_wdata` and each processor read of the data register returns and removes the oldest word. `irq` is high while the interrupt is enabled and the level is at or above half the depth.
- R11: Data-register accesses against the direction have no effect. In playback, a data read returns 0 and removes nothing. In capture, a data write queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 3 | Capacity size code |
| cfg_chan_m1 | input | 3 | Channel count minus one |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read pops in capture) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the read |
| ser_strobe | input | 1 | One channel slot from the serializer |
| ser_wdata | input | 24 | Capture sample from the serializer |
| ser_rdata | output | 24 | Playback sample to the serializer |
| irq | output | 1 | Half-level interrupt request |

## Verification
The assertions assume three things about the inputs: `cfg_size` and `cfg_chan_m1` stay constant between clears, `reg_wr` and `reg_rd` are never high together, and every strobe lasts exactly one cycle per access. The bench meets these by changing the configuration only while the FIFO is empty and just before a clear. It drives every strobe from tasks that raise it for one cycle at a falling edge. The bench keeps its own queue of the words the FIFO should hold and a formula for the capacity. It compares each serializer or processor pop against that queue.

// File: rtl/psf_pkg.sv
package psf_pkg;
   localparam int SMP_W   = 24;
   localparam int LVL_W   = 9;
   localparam int LVL_MAX = (1 << LVL_W) - 1;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_DATA = 2'd2
   } reg_sel_e;

   localparam int CTL_FLUSH_BIT = 0;
   localparam int CTL_HALF_BIT  = 20;
   localparam int ST_UNDER_BIT  = 0;
   localparam int ST_OVER_BIT   = 4;
   localparam int ST_LVL_LSB    = 8;

   // number of halvings: channels rounded up to a power-of-two group
   function automatic logic [1:0] grp_shift(input logic [2:0] chan_m1);
      case (chan_m1)
         3'd0:       grp_shift = 2'd0;
         3'd1:       grp_shift = 2'd1;
         3'd2, 3'd3: grp_shift = 2'd2;
         default:    grp_shift = 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/psf_geom.sv
module psf_geom
   import psf_pkg::*;
#(
   parameter int MAX_SIZE_CODE = 1,
   parameter int CNT_W         = 10
) (
   input  logic [2:0]       cfg_size,
   input  logic [2:0]       cfg_chan_m1,
   output logic [CNT_W-1:0] depth,
   output logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] half
);
   localparam logic [2:0] SZ_TOP = 3'(MAX_SIZE_CODE);

   logic [2:0]       sz_eff;
   logic [CNT_W-1:0] cap;
   logic [CNT_W-1:0] chans;

   always_comb begin
      sz_eff = (cfg_size > SZ_TOP) ? SZ_TOP : cfg_size;
      cap    = CNT_W'(256) << sz_eff;
      depth  = cap >> grp_shift(cfg_chan_m1);
      chans  = CNT_W'(cfg_chan_m1) + CNT_W'(1);
      limit  = depth * chans;
      half   = depth >> 1;
   end
endmodule

// File: rtl/psf_store.sv
module psf_store
   import psf_pkg::*;
#(
   parameter int CAP_MAX = 512,
   parameter int CNT_W   = 10,
   localparam int AW     = $clog2(CAP_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [SMP_W-1:0] push_data,
   input  logic             pop,
   input  logic [CNT_W-1:0] limit,
   input  logic [2:0]       cfg_chan_m1,
   output logic [SMP_W-1:0] head_data,
   output logic             empty,
   output logic             full,
   output logic             over_evt,
   output logic             under_evt,
   output logic [CNT_W-1:0] frames
);
   logic [SMP_W-1:0] mem [CAP_MAX];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic [2:0]       wr_ch, rd_ch;
   logic             push_acc, pop_acc, frm_in, frm_out;
   logic [AW-1:0]    wr_nxt, rd_nxt;

   always_comb begin
      empty     = (count == '0);
      full      = (count == limit);
      push_acc  = push & ~full & ~flush;
      pop_acc   = pop & ~empty & ~flush;
      over_evt  = push & full & ~flush;
      under_evt = pop & empty & ~flush;
      frm_in    = push_acc & (wr_ch == cfg_chan_m1);
      frm_out   = pop_acc & (rd_ch == cfg_chan_m1);
      wr_nxt    = ((CNT_W'(wr_ptr) + CNT_W'(1)) == limit) ? '0 : wr_ptr + AW'(1);
      rd_nxt    = ((CNT_W'(rd_ptr) + CNT_W'(1)) == limit) ? '0 : rd_ptr + AW'(1);
      head_data = empty ? '0 : mem[rd_ptr];
   end

   always_ff @(posedge clk) begin
      if (push_acc) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         frames <= '0;
         wr_ch  <= '0;
         rd_ch  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         frames <= '0;
         wr_ch  <= '0;
         rd_ch  <= '0;
      end else begin
         if (push_acc) begin
            wr_ptr <= wr_nxt;
            wr_ch  <= (wr_ch == cfg_chan_m1) ? 3'd0 : wr_ch + 3'd1;
         end
         if (pop_acc) begin
            rd_ptr <= rd_nxt;
            rd_ch  <= (rd_ch == cfg_chan_m1) ? 3'd0 : rd_ch + 3'd1;
         end
         count  <= count + CNT_W'(push_acc) - CNT_W'(pop_acc);
         frames <= frames + CNT_W'(frm_in) - CNT_W'(frm_out);
      end
   end
endmodule

// File: rtl/psf_regs.sv
module psf_regs
   import psf_pkg::*;
#(
   parameter bit CAPTURE = 1'b0,
   parameter int CNT_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   input  logic             over_evt,
   input  logic             under_evt,
   input  logic [CNT_W-1:0] frames,
   input  logic [CNT_W-1:0] half,
   input  logic [SMP_W-1:0] head_data,
   output logic [31:0]      reg_rdata,
   output logic             flush,
   output logic             half_ie,
   output logic             flag_over,
   output logic             flag_under,
   output logic             irq
);
   logic             ctl_wr, st_wr, lvl_hit;
   logic [LVL_W-1:0] lvl_rep;

   always_comb begin
      ctl_wr = reg_wr & (reg_addr == SEL_CTRL);
      st_wr  = reg_wr & (reg_addr == SEL_STAT);
      flush  = ctl_wr & reg_wdata[CTL_FLUSH_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_ie    <= 1'b0;
         flag_over  <= 1'b0;
         flag_under <= 1'b0;
      end else begin
         if (ctl_wr) half_ie <= reg_wdata[CTL_HALF_BIT];
         flag_over  <= over_evt  | (flag_over  & ~(st_wr & ~reg_wdata[ST_OVER_BIT]));
         flag_under <= under_evt | (flag_under & ~(st_wr & ~reg_wdata[ST_UNDER_BIT]));
      end
   end

   generate
      if (CAPTURE) begin : g_cap_irq
         assign lvl_hit = (frames >= half);
      end else begin : g_play_irq
         assign lvl_hit = (frames <= half);
      end
   endgenerate

   assign irq = half_ie & lvl_hit;

   always_comb begin
      lvl_rep   = (frames > CNT_W'(LVL_MAX)) ? LVL_W'(LVL_MAX) : LVL_W'(frames);
      reg_rdata = '0;
      case (reg_addr)
         SEL_CTRL: reg_rdata[CTL_HALF_BIT] = half_ie;
         SEL_STAT: begin
            reg_rdata[ST_LVL_LSB +: LVL_W] = lvl_rep;
            reg_rdata[ST_OVER_BIT]         = flag_over;
            reg_rdata[ST_UNDER_BIT]        = flag_under;
         end
         SEL_DATA: reg_rdata[SMP_W-1:0] = CAPTURE ? head_data : '0;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo
   import psf_pkg::*;
#(
   parameter bit CAPTURE       = 1'b0,
   parameter int MAX_SIZE_CODE = 1,
   localparam int CAP_MAX      = 256 << MAX_SIZE_CODE,
   localparam int CNT_W        = $clog2(CAP_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cfg_size,
   input  logic [2:0]       cfg_chan_m1,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic             ser_strobe,
   input  logic [SMP_W-1:0] ser_wdata,
   output logic [SMP_W-1:0] ser_rdata,
   output logic             irq
);
   generate
      if (MAX_SIZE_CODE < 0 || MAX_SIZE_CODE > 3) begin : g_bad_size
         $error("MAX_SIZE_CODE must lie in 0..3");
      end
   endgenerate

   logic [CNT_W-1:0] depth, limit, half, frames;
   logic             push_req, pop_req, flush, half_ie;
   logic             fifo_empty, fifo_full, over_evt, under_evt;
   logic             flag_over, flag_under;
   logic [SMP_W-1:0] push_dat, head_dat;
   logic             data_wr, data_rd;

   assign data_wr = reg_wr & (reg_addr == SEL_DATA);
   assign data_rd = reg_rd & (reg_addr == SEL_DATA);

   generate
      if (CAPTURE) begin : g_capture
         assign push_req  = ser_strobe;
         assign push_dat  = ser_wdata;
         assign pop_req   = data_rd;
         assign ser_rdata = '0;
      end else begin : g_playback
         assign push_req  = data_wr;
         assign push_dat  = reg_wdata[SMP_W-1:0];
         assign pop_req   = ser_strobe;
         assign ser_rdata = head_dat;
      end
   endgenerate

   psf_geom #(.MAX_SIZE_CODE(MAX_SIZE_CODE), .CNT_W(CNT_W)) geom_i (
      .cfg_size    (cfg_size),
      .cfg_chan_m1 (cfg_chan_m1),
      .depth       (depth),
      .limit       (limit),
      .half        (half)
   );

   psf_store #(.CAP_MAX(CAP_MAX), .CNT_W(CNT_W)) store_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .push        (push_req),
      .push_data   (push_dat),
      .pop         (pop_req),
      .limit       (limit),
      .cfg_chan_m1 (cfg_chan_m1),
      .head_data   (head_dat),
      .empty       (fifo_empty),
      .full        (fifo_full),
      .over_evt    (over_evt),
      .under_evt   (under_evt),
      .frames      (frames)
   );

   psf_regs #(.CAPTURE(CAPTURE), .CNT_W(CNT_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .over_evt   (over_evt),
      .under_evt  (under_evt),
      .frames     (frames),
      .half       (half),
      .head_data  (head_dat),
      .reg_rdata  (reg_rdata),
      .flush      (flush),
      .half_ie    (half_ie),
      .flag_over  (flag_over),
      .flag_under (flag_under),
      .irq        (irq)
   );
endmodule

// File: rtl/pcm_sample_fifo_chk.sv
module pcm_sample_fifo_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_req,
   input logic             pop_req,
   input logic             flush,
   input logic             fifo_empty,
   input logic             fifo_full,
   input logic [23:0]      head_dat,
   input logic [CNT_W-1:0] frames,
   input logic [CNT_W-1:0] depth,
   input logic             flag_over,
   input logic             flag_under,
   input logic             half_ie,
   input logic             irq
);
   // R5
   no_drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && fifo_full && !flush) |=> flag_over);
   // R6
   underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && fifo_empty && !flush) |=> flag_under);
   // R6
   underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && fifo_empty) |-> (head_dat == 24'd0));
   // R4
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frames <= depth);
   // R8
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (fifo_empty && frames == '0));
   // R8
   flush_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !pop_req) |=> ($stable(flag_over) && $stable(flag_under)));
   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !half_ie |-> !irq);
endmodule

bind pcm_sample_fifo pcm_sample_fifo_chk #(.CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_req   (push_req),
   .pop_req    (pop_req),
   .flush      (flush),
   .fifo_empty (fifo_empty),
   .fifo_full  (fifo_full),
   .head_dat   (head_dat),
   .frames     (frames),
   .depth      (depth),
   .flag_over  (flag_over),
   .flag_under (flag_under),
   .half_ie    (half_ie),
   .irq        (irq)
);

// File: tb/pcm_sample_fifo_tb_top.sv
`timescale 1ns/1ps
module pcm_sample_fifo_tb_top;
   localparam int MAXC = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [2:0]  p_size = '0, p_chm1 = '0, c_size = '0, c_chm1 = '0;
   logic        p_wr = 0, p_rd = 0, p_stb = 0, c_wr = 0, c_rd = 0, c_stb = 0;
   logic [1:0]  p_addr = '0, c_addr = '0;
   logic [31:0] p_wdata = '0, c_wdata = '0, p_rdata, c_rdata;
   logic [23:0] p_sin = '0, c_sin = '0, p_sout, c_sout;
   logic        p_irq, c_irq;

   pcm_sample_fifo #(.CAPTURE(1'b0), .MAX_SIZE_CODE(MAXC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_size(p_size), .cfg_chan_m1(p_chm1),
      .reg_wr(p_wr), .reg_rd(p_rd), .reg_addr(p_addr), .reg_wdata(p_wdata),
      .reg_rdata(p_rdata), .ser_strobe(p_stb), .ser_wdata(p_sin),
      .ser_rdata(p_sout), .irq(p_irq));

   pcm_sample_fifo #(.CAPTURE(1'b1), .MAX_SIZE_CODE(MAXC)) dut_cap_i (
      .clk(clk), .rst_n(rst_n), .cfg_size(c_size), .cfg_chan_m1(c_chm1),
      .reg_wr(c_wr), .reg_rd(c_rd), .reg_addr(c_addr), .reg_wdata(c_wdata),
      .reg_rdata(c_rdata), .ser_strobe(c_stb), .ser_wdata(c_sin),
      .ser_rdata(c_sout), .irq(c_irq));

   int checks = 0, fails = 0;
   bit done = 0;
   logic [23:0] exp_q [$];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int exp_depth(int size, int chans);
      int cap = 256 << ((size > MAXC) ? MAXC : size);
      int g = 1;
      while (g < chans) begin g = g * 2; cap = cap / 2; end
      return cap;
   endfunction

   function automatic logic [31:0] stat(int lvl, bit ov, bit un);
      return (32'(lvl) << 8) | (32'(ov) << 4) | 32'(un);
   endfunction

   task automatic reg_write(bit cap, logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      if (cap) begin c_wr = 1; c_addr = a; c_wdata = d; end
      else begin p_wr = 1; p_addr = a; p_wdata = d; end
      @(negedge clk);
      c_wr = 0; p_wr = 0;
   endtask

   task automatic reg_read(bit cap, logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      if (cap) begin c_rd = 1; c_addr = a; end
      else begin p_rd = 1; p_addr = a; end
      #1 d = cap ? c_rdata : p_rdata;
      @(negedge clk);
      c_rd = 0; p_rd = 0;
   endtask

   task automatic ser_slot(bit cap, logic [23:0] din, output logic [23:0] dout);
      @(negedge clk);
      if (cap) begin c_stb = 1; c_sin = din; end else p_stb = 1;
      #1 dout = p_sout;
      @(negedge clk);
      c_stb = 0; p_stb = 0;
   endtask

   // driver: writes a sample and records it if the model has room
   task automatic drv_push(logic [31:0] d, int lim);
      reg_write(0, 2'd2, d);
      if (exp_q.size() < lim) exp_q.push_back(d[23:0]);
   endtask

   // monitor: takes one serializer sample and compares it with the queue
   task automatic mon_pop(string req);
      logic [23:0] v;
      logic [23:0] e;
      ser_slot(0, '0, v);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 24'd0;
      check(req, 32'(v), 32'(e));
   endtask

   task automatic flush_all(bit cap);
      reg_write(cap, 2'd0, 32'h1);
      reg_write(cap, 2'd1, 32'h0);
      exp_q.delete();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [23:0] s;
      int d, lim;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      reg_read(0, 2'd0, r); check("R1 ctrl", r, 0);
      reg_read(0, 2'd1, r); check("R1 stat", r, 0);
      #1 check("R1 irq", 32'(p_irq), 0);

      // R2 / R4 / R11 two channels
      p_size = 0; p_chm1 = 1; lim = exp_depth(0, 2) * 2;
      drv_push(32'hFF123456, lim); drv_push(32'h00000A0B, lim);
      drv_push(32'h00ABCDEF, lim); drv_push(32'h7F000001, lim);
      reg_read(0, 2'd1, r); check("R4 level two frames", r, stat(2, 0, 0));
      reg_read(0, 2'd2, r); check("R11 playback data read", r, 0);
      reg_read(0, 2'd1, r); check("R11 level kept", r, stat(2, 0, 0));
      mon_pop("R2 upper bits dropped");
      reg_read(0, 2'd1, r); check("R4 partial frame popped", r, stat(2, 0, 0));
      mon_pop("R2 order");
      reg_read(0, 2'd1, r); check("R4 frame popped", r, stat(1, 0, 0));
      mon_pop("R2 order"); mon_pop("R2 order");

      // R6 / R7 underrun and flag clearing
      ser_slot(0, '0, s); check("R6 empty pop value", 32'(s), 0);
      reg_read(0, 2'd1, r); check("R6 underrun flag", r, stat(0, 0, 1));
      reg_write(0, 2'd1, 32'h1);
      reg_read(0, 2'd1, r); check("R7 written one keeps", r, stat(0, 0, 1));
      reg_write(0, 2'd1, 32'h0);
      reg_read(0, 2'd1, r); check("R7 written zero clears", r, stat(0, 0, 0));

      // R3 / R5 one channel size 0
      p_chm1 = 0; d = exp_depth(0, 1); lim = d;
      check("R3 depth formula 1ch", 32'(d), 256);
      for (int i = 0; i <= lim; i++) drv_push(32'(i * 7 + 3), lim);
      reg_read(0, 2'd1, r); check("R5 overrun full", r, stat(256, 1, 0));
      for (int i = 0; i < lim; i++) mon_pop("R5 contents intact");
      reg_write(0, 2'd1, 32'h0);

      // R3 / R8 three channels use a four-channel unit
      p_chm1 = 2; d = exp_depth(0, 3); lim = d * 3;
      for (int i = 0; i <= lim; i++) drv_push(32'(i), lim);
      reg_read(0, 2'd1, r); check("R3 3ch depth", r, stat(64, 1, 0));
      reg_write(0, 2'd0, 32'h1); exp_q.delete();
      reg_read(0, 2'd1, r); check("R8 flush keeps flag", r, stat(0, 1, 0));
      reg_read(0, 2'd0, r); check("R8 flush bit reads 0", r, 0);
      ser_slot(0, '0, s); check("R8 empty after flush", 32'(s), 0);
      reg_read(0, 2'd1, r); check("R8 underrun after flush", r, stat(0, 1, 1));
      reg_write(0, 2'd1, 32'h0);

      // R3 five channels, size code above the build limit clamps
      p_size = 3'd5; p_chm1 = 4; d = exp_depth(5, 5); lim = d * 5;
      for (int i = 0; i < lim; i++) drv_push(32'(i), lim);
      reg_read(0, 2'd1, r); check("R3 5ch clamp no overrun", r, stat(64, 0, 0));
      drv_push(32'h55, lim);
      reg_read(0, 2'd1, r); check("R3 5ch limit", r, stat(64, 1, 0));
      flush_all(0);

      // R4 saturation
      p_size = 1; p_chm1 = 0; lim = exp_depth(1, 1);
      for (int i = 0; i < lim; i++) drv_push(32'(i), lim);
      reg_read(0, 2'd1, r); check("R4 level saturates", r, stat(511, 0, 0));
      flush_all(0);

      // R9 playback half interrupt
      p_size = 0; p_chm1 = 1; d = exp_depth(0, 2); lim = d * 2;
      #1 check("R9 disabled", 32'(p_irq), 0);
      reg_write(0, 2'd0, 32'h0010_0000);
      #1 check("R9 empty enabled", 32'(p_irq), 1);
      for (int i = 0; i < (d / 2 + 1) * 2; i++) drv_push(32'(i), lim);
      #1 check("R9 above half", 32'(p_irq), 0);
      mon_pop("R9 data"); mon_pop("R9 data");
      #1 check("R9 at half", 32'(p_irq), 1);
      reg_write(0, 2'd0, 32'h0);
      #1 check("R9 enable off", 32'(p_irq), 0);
      flush_all(0);

      // R10 / R11 capture
      c_size = 0; c_chm1 = 0; d = exp_depth(0, 1);
      reg_write(1, 2'd0, 32'h0010_0000);
      #1 check("R10 irq empty", 32'(c_irq), 0);
      for (int i = 0; i < d / 2; i++) begin
         ser_slot(1, 24'(i * 5 + 1), s);
         exp_q.push_back(24'(i * 5 + 1));
      end
      #1 check("R10 irq at half", 32'(c_irq), 1);
      reg_write(1, 2'd2, 32'h00FFFFFF);
      reg_read(1, 2'd1, r); check("R11 capture write ignored", r, stat(d / 2, 0, 0));
      for (int i = 0; i < d / 2; i++) begin
         reg_read(1, 2'd2, r);
         check("R10 capture order", r, 32'(exp_q.pop_front()));
      end
      #1 check("R10 irq below half", 32'(c_irq), 0);
      reg_read(1, 2'd2, r); check("R6 capture empty read", r, 0);
      reg_read(1, 2'd1, r); check("R6 capture underrun", r, stat(0, 0, 1));

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule